// File: doc/BRIEF.md
# Transfer Unit Symbol Scheduler

This block paces active pixel data onto one lane of a serial display link. Every link clock with the clock enable high is one symbol slot, and the slots are grouped into transfer units of a programmed length. Each unit opens with a run of valid-data slots, and the rest of the unit is filler. A downstream packer uses the per-slot flags to choose between taking a data symbol from its pixel buffer and inserting a stuffing symbol. It uses the unit-boundary marker to frame units.

The number of valid slots per unit is either fixed or moderated. When moderation is on, the scheduler runs a repeating pattern of a programmed number of "upper" units that carry the full valid count, then a programmed number of "lower" units that carry the lower valid count, which is normally one less. This lets the average valid density per unit be a fraction. A line start restarts the pattern and arms a start delay, so the first unit of a line begins a programmed number of enabled link clocks later.

The flags are plain per-slot strobes with no back-pressure. The only throttle is `link_en`: while it is low, no slot is consumed and every counter holds. The configuration is meant to stay stable for the whole line. Computing the parameters, buffering pixels and striping lanes are done elsewhere.

Top module: `tu_sched`

## Requirements
- R1: After reset, and until the first `line_start`, all three outputs stay low even with `link_en` high.
- R2: The start delay D is `cfg_a[31:16]`. After the clock edge that samples `line_start`, the first D enabled cycles emit no flags, and the first slot of the line appears in the next enabled cycle. When D is 0, that slot is the cycle right after the edge.
- R3: A unit is `tu_len_m1 + 1` slots long. `unit_end` is high on the last slot of each unit and on no other slot, and units follow each other with no gap.
- R4: In each unit, the leading slots up to the unit's valid count raise `slot_valid`, and every later slot raises `slot_fill`. Exactly one of the two is high in each enabled active cycle.
- R5: When the moderation enable `cfg_b[0]` is 1, the scheduler emits `cfg_b[19:16]` units with the valid count `cfg_a[6:0]`, then `cfg_b[23:20]` units with the lower valid count `cfg_b[7:1]`, and repeats this pattern for the rest of the line.
- R6: When `cfg_b[0]` is 0, every unit uses `cfg_a[6:0]`, whatever the group counts and the lower valid count hold.
- R7: Every `line_start` restarts the pattern with an upper unit and reloads the start delay, even in the middle of a unit or of a lower group.
- R8: While `link_en` is low, all outputs are low and no counter advances. The slot sequence picks up where it stopped when `link_en` returns.
- R9: With the bypass setting (`tu_len_m1` = 31, valid count 32, D = 0, moderation off), every slot is valid, no filler appears, and `unit_end` pulses every 32 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start of line; restarts pattern and delay |
| link_en | input | 1 | Clock enable; a slot is consumed only when high |
| tu_len_m1 | input | 6 | Unit length minus one |
| cfg_a | input | 32 | [6:0] valid count, [31:16] start delay |
| cfg_b | input | 32 | [0] moderation enable, [7:1] lower valid count, [19:16] upper unit count, [23:20] lower unit count |
| slot_valid | output | 1 | Current slot carries data |
| slot_fill | output | 1 | Current slot carries filler |
| unit_end | output | 1 | Current slot is the last of its unit |

## Verification
The flags decode registered counters combined with the current `link_en`. A slot's flags therefore belong to the same cycle in which the enable is driven, and a `line_start` takes effect one edge after it is sampled. The bench drives its inputs just after each rising edge and, in the same step, queues the flags it expects for that cycle. A monitor pops and compares them at the falling edge. A line is always started in a cycle with the enable low, so the expected flags for that cycle are zero no matter what state the scheduler is leaving. The expected stream is built from the slot index counted from the start of the line, minus the delay. Enabled cycles advance that index, and disabled cycles expect all flags low.

// File: rtl/tu_sched_pkg.sv
package tu_sched_pkg;
  typedef enum logic [1:0] {
    LN_IDLE   = 2'd0,
    LN_DELAY  = 2'd1,
    LN_ACTIVE = 2'd2
  } line_state_e;

  // Field positions inside the two configuration words.
  localparam int VHI_LSB  = 0;
  localparam int DLY_LSB  = 16;
  localparam int MOD_BIT  = 0;
  localparam int VLO_LSB  = 1;
  localparam int UCNT_LSB = 16;
  localparam int LCNT_LSB = 20;
endpackage

// File: rtl/tu_cfg_decode.sv
module tu_cfg_decode
  import tu_sched_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int SYM_W = 7,
  parameter int DLY_W = 16,
  parameter int GRP_W = 4
) (
  input  logic [CFG_W-1:0] cfg_a,
  input  logic [CFG_W-1:0] cfg_b,
  output logic [SYM_W-1:0] v_hi,
  output logic [SYM_W-1:0] v_lo,
  output logic [DLY_W-1:0] delay,
  output logic             mod_en,
  output logic [GRP_W-1:0] up_cnt,
  output logic [GRP_W-1:0] lo_cnt
);
  logic unused_bits;

  always_comb begin
    v_hi   = cfg_a[VHI_LSB +: SYM_W];
    delay  = cfg_a[DLY_LSB +: DLY_W];
    mod_en = cfg_b[MOD_BIT];
    v_lo   = cfg_b[VLO_LSB +: SYM_W];
    up_cnt = cfg_b[UCNT_LSB +: GRP_W];
    lo_cnt = cfg_b[LCNT_LSB +: GRP_W];
  end

  assign unused_bits = ^{cfg_a, cfg_b};
endmodule

// File: rtl/tu_line_timer.sv
module tu_line_timer
  import tu_sched_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             en,
  input  logic [DLY_W-1:0] delay,
  output logic             active
);
  line_state_e      state_q;
  logic [DLY_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LN_IDLE;
      wait_q  <= '0;
    end else if (line_start) begin
      state_q <= (delay == '0) ? LN_ACTIVE : LN_DELAY;
      wait_q  <= delay;
    end else if (en && state_q == LN_DELAY) begin
      wait_q <= wait_q - 1'b1;
      if (wait_q == DLY_W'(1)) state_q <= LN_ACTIVE;
    end
  end

  assign active = (state_q == LN_ACTIVE);
endmodule

// File: rtl/tu_unit_counter.sv
module tu_unit_counter #(
  parameter int SYM_W = 7,
  parameter int GRP_W = 4,
  localparam int LEN_W = SYM_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [SYM_W-1:0] v_hi,
  input  logic [SYM_W-1:0] v_lo,
  input  logic             mod_en,
  input  logic [GRP_W-1:0] up_cnt,
  input  logic [GRP_W-1:0] lo_cnt,
  output logic             data_slot,
  output logic             last_slot,
  output logic [SYM_W-1:0] slot_idx
);
  logic [SYM_W-1:0] slot_q;
  logic             lower_q;
  logic [GRP_W-1:0] grp_q;
  logic [SYM_W-1:0] v_cur;
  logic             grp_done;

  always_comb begin
    v_cur     = (mod_en && lower_q) ? v_lo : v_hi;
    data_slot = slot_q < v_cur;
    last_slot = slot_q == {1'b0, len_m1};
    grp_done  = ({1'b0, grp_q} + 1'b1) >= {1'b0, (lower_q ? lo_cnt : up_cnt)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      slot_q  <= '0;
      lower_q <= 1'b0;
      grp_q   <= '0;
    end else if (step) begin
      if (last_slot) begin
        slot_q <= '0;
        if (mod_en) begin
          if (grp_done) begin
            lower_q <= !lower_q;
            grp_q   <= '0;
          end else begin
            grp_q <= grp_q + 1'b1;
          end
        end
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign slot_idx = slot_q;
endmodule

// File: rtl/tu_sched.sv
module tu_sched #(
  parameter int CFG_W = 32,
  parameter int SYM_W = 7,
  parameter int DLY_W = 16,
  parameter int GRP_W = 4,
  localparam int LEN_W = SYM_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             link_en,
  input  logic [LEN_W-1:0] tu_len_m1,
  input  logic [CFG_W-1:0] cfg_a,
  input  logic [CFG_W-1:0] cfg_b,
  output logic             slot_valid,
  output logic             slot_fill,
  output logic             unit_end
);
  logic [SYM_W-1:0] v_hi, v_lo, slot_idx;
  logic [DLY_W-1:0] delay;
  logic             mod_en, active, step, data_slot, last_slot;
  logic [GRP_W-1:0] up_cnt, lo_cnt;

  tu_cfg_decode #(.CFG_W(CFG_W), .SYM_W(SYM_W), .DLY_W(DLY_W), .GRP_W(GRP_W)) u_dec (
    .cfg_a(cfg_a), .cfg_b(cfg_b), .v_hi(v_hi), .v_lo(v_lo), .delay(delay),
    .mod_en(mod_en), .up_cnt(up_cnt), .lo_cnt(lo_cnt)
  );

  tu_line_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .en(link_en),
    .delay(delay), .active(active)
  );

  assign step = active && link_en;

  tu_unit_counter #(.SYM_W(SYM_W), .GRP_W(GRP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(line_start), .step(step),
    .len_m1(tu_len_m1), .v_hi(v_hi), .v_lo(v_lo), .mod_en(mod_en),
    .up_cnt(up_cnt), .lo_cnt(lo_cnt), .data_slot(data_slot),
    .last_slot(last_slot), .slot_idx(slot_idx)
  );

  assign slot_valid = step && data_slot;
  assign slot_fill  = step && !data_slot;
  assign unit_end   = step && last_slot;
endmodule

// File: rtl/tu_sched_chk.sv
module tu_sched_chk
  import tu_sched_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int SYM_W = 7,
  parameter int DLY_W = 16,
  localparam int LEN_W = SYM_W - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             link_en,
  input logic [LEN_W-1:0] tu_len_m1,
  input logic [CFG_W-1:0] cfg_a,
  input logic [CFG_W-1:0] cfg_b,
  input logic             slot_valid,
  input logic             slot_fill,
  input logic             unit_end,
  input logic [SYM_W-1:0] slot_idx
);
  logic unused_cfg;
  assign unused_cfg = ^{cfg_a, cfg_b};

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_valid && slot_fill)); // R4

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |-> !(slot_valid || slot_fill || unit_end)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_en && !line_start) |=> $stable(slot_idx)); // R8

  AST_END_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    unit_end |-> (slot_valid || slot_fill)); // R3

  AST_END_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && !line_start) |=> (slot_idx == '0)); // R3

  AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && cfg_a[DLY_LSB +: DLY_W] != '0) |=> !(slot_valid || slot_fill)); // R2

  AST_BYPASS_NOFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (tu_len_m1 == LEN_W'(31) && cfg_a[VHI_LSB +: SYM_W] == SYM_W'(32) && !cfg_b[MOD_BIT])
      |-> !slot_fill); // R9
endmodule

bind tu_sched tu_sched_chk #(.CFG_W(CFG_W), .SYM_W(SYM_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .link_en(link_en),
  .tu_len_m1(tu_len_m1), .cfg_a(cfg_a), .cfg_b(cfg_b), .slot_valid(slot_valid),
  .slot_fill(slot_fill), .unit_end(unit_end), .slot_idx(slot_idx)
);

// File: tb/tu_sched_tb.sv
module tu_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        link_en = 1'b0;
  logic [5:0]  tu_len_m1 = '0;
  logic [31:0] cfg_a = '0;
  logic [31:0] cfg_b = '0;
  logic        slot_valid, slot_fill, unit_end;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  tu_sched u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .link_en(link_en),
    .tu_len_m1(tu_len_m1), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .slot_valid(slot_valid), .slot_fill(slot_fill), .unit_end(unit_end)
  );

  // Monitor: compare observed flags {valid, fill, end} against the scoreboard.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if ({slot_valid, slot_fill, unit_end} !== e) begin
        n_fail++;
        $display("FAIL %s: flags v/f/e actual=%b expected=%b at %0t",
                 t, {slot_valid, slot_fill, unit_end}, e, $time);
      end
    end
  end

  // Expected flags for enabled cycle j counted from line start.
  function automatic logic [2:0] model(int j, int d, int len, int vh, int vl,
                                       bit md, int uc, int lc);
    int k, u, p, vc;
    if (j < d) return 3'b000;
    k = j - d;
    u = k / len;
    p = k % len;
    vc = (md && (u % (uc + lc)) >= uc) ? vl : vh;
    return {p < vc, p >= vc, p == len - 1};
  endfunction

  task automatic push(logic [2:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Driver: start a line in a disabled cycle, then run ncyc cycles.
  // gap > 0 drops link_en on every gap-th cycle.
  task automatic run_line(string t, int m1, int vh, int dly, bit md, int vl,
                          int uc, int lc, int ncyc, int gap);
    int j;
    @(posedge clk); #1;
    tu_len_m1 = 6'(m1);
    cfg_a = {16'(dly), 9'd0, 7'(vh)};
    cfg_b = {8'd0, 4'(lc), 4'(uc), 8'd0, 7'(vl), md};
    line_start = 1'b1;
    link_en = 1'b0;
    push(3'b000, t);
    j = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #1;
      line_start = 1'b0;
      link_en = !(gap > 0 && (i % gap) == gap - 1);
      if (link_en) begin
        push(model(j, dly, m1 + 1, vh, vl, md, uc, lc), j < dly ? "R2" : t);
        j++;
      end else begin
        push(3'b000, "R8");
      end
    end
  endtask

  initial begin
    // R1: reset state and idle before any line start
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    link_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      push(3'b000, "R1");
    end
    // R9: bypass setting
    run_line("R9 R3 R4", 31, 32, 0, 1'b0, 0, 0, 0, 100, 0);
    // R6: moderation off with counts present; R2 delay of 5
    run_line("R6 R3 R4", 39, 27, 5, 1'b0, 26, 3, 2, 130, 0);
    // R5: 3 upper units of 20, then 2 lower units of 19
    run_line("R5 R4", 35, 20, 3, 1'b1, 19, 3, 2, 36 * 12, 0);
    // R8: stalls every fifth cycle, 1 upper then 15 lower
    run_line("R8 R5", 32, 10, 7, 1'b1, 9, 1, 15, 33 * 20, 5);
    // R7: line cut inside the lower group, then restarted
    run_line("R7 R5", 31, 17, 0, 1'b1, 16, 2, 3, 32 * 3 + 5, 0);
    run_line("R7 R5", 31, 17, 0, 1'b1, 16, 2, 3, 32 * 6, 0);
    // R3: longest unit with one valid slot and a delay of 1
    run_line("R3 R4 R2", 63, 1, 1, 1'b0, 0, 0, 0, 64 * 3, 0);
    @(posedge clk); #1;
    link_en = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule